// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-load logic of a byte-programmable nonvolatile array. It watches every byte load, given as a strobe with an address and a data byte, and every load-window-ended strobe, which marks the moment a page's loading stops and the busy period begins. From these it keeps a persistent software write-protect mode. For each program cycle it decides whether the loaded page may be committed to the array. If not, the page is dropped, and the busy timing elsewhere still runs.

While protection is off, every page is committed. An arming key of three loads at the very start of a window turns protection on, and the page loaded after it is still committed. The key is 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. While protection is on, a window commits only when it opens with that same key. Otherwise the page is dropped and the mode stays on.

A six-load disarm sequence at the start of a window turns protection off. It is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. Loads that belong to a command are flagged as consumed so that the page buffer skips them. The mode register models nonvolatile storage: the ordinary reset leaves it alone, and only the power-on-default input clears it.

Top module: `wp_cmd_detect`

## Requirements
- R1: While `por_default` is high, at the next clock edge `prot_on`, `commit_en` and `consumed` all become 0; protection is off in the default state.
- R2: The ordinary reset `rst` clears the sequence matcher and the window state, but `prot_on` keeps its value across it.
- R3: When the first three loads of a window are 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 (address/data), `prot_on` is 1 from the cycle after `win_end` is sampled.
- R4: `consumed` is 1 in the cycle after a load if, counting from the window start, that load and all earlier loads of the window form a prefix of the arming key or of the disarm sequence. Otherwise it is 0.
- R5: A load that breaks the prefix ends command matching for the rest of the window. That load and all later loads in the window give `consumed` = 0.
- R6: With `prot_on` = 1, a window that does not open with the arming key gives `commit_en` = 0 after `win_end`, and `prot_on` stays 1.
- R7: With `prot_on` = 1, a window that opens with the arming key gives a `commit_en` pulse in the cycle after `win_end`.
- R8: With `prot_on` = 0, every `win_end` is followed one cycle later by a `commit_en` pulse.
- R9: When the first six loads of a window are the disarm sequence, `prot_on` becomes 0 in the cycle after `win_end`, and `commit_en` pulses in that cycle.
- R10: `commit_en` is high only in the cycle right after a sampled `win_end`, and it lasts one cycle.
- R11: An arming key that follows an ordinary data load in the same window is not recognised. Its loads are not consumed, and with protection on the page is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of matcher and window state; leaves the protect mode unchanged |
| por_default | input | 1 | Synchronous power-on default; also clears the protect mode |
| ld_stb | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | DATA_W | Load data |
| win_end | input | 1 | Load window has ended; the program cycle is decided |
| prot_on | output | 1 | Software write-protect mode (registered) |
| commit_en | output | 1 | One-cycle pulse: commit the loaded page |
| consumed | output | 1 | The previous cycle's load was a command byte, not page data |

## Verification
The bench uses the default parameters: a 15-bit address, 8-bit data, and the command addresses and codes listed above. At 15 bits, a uniformly random address almost never hits a command address. The random loads therefore pick 0x5555 or 0x2AAA three times in four and pick a command code for the data most of the time. This makes full keys, partial prefixes broken at each step, and near-miss disarm attempts all occur, in both protect states. Directed windows cover the corners: a key placed after a data load, reset with protection on, and power-on default after re-arming.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  localparam int DIS_LEN = 6;
  localparam int KEY_LEN = 3;
  localparam int STEP_W  = $clog2(DIS_LEN + 1);

  typedef enum logic [1:0] {
    LD_DATA     = 2'd0,
    LD_PREFIX   = 2'd1,
    LD_KEY_DONE = 2'd2,
    LD_DIS_DONE = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/wp_seq_matcher.sv
`timescale 1ns/1ps
module wp_seq_matcher import wp_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_OPEN   = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_CONF   = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM    = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_ERASE  = 8'h80,
  parameter logic [DATA_W-1:0] CODE_DISARM = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_end,
  output ld_kind_e          kind
);
  localparam int STEPS = DIS_LEN;

  logic [STEPS-1:0]  hit;
  logic              key_hit;
  logic [STEP_W-1:0] idx;
  logic              live;

  // Disarm sequence steps; the arming key shares steps 0 and 1.
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    localparam logic [ADDR_W-1:0] S_ADDR = (i == 1 || i == 4) ? ADDR_Q : ADDR_P;
    localparam logic [DATA_W-1:0] S_DATA =
      (i == 0 || i == 3) ? CODE_OPEN :
      (i == 1 || i == 4) ? CODE_CONF :
      (i == 2)           ? CODE_ERASE : CODE_DISARM;
    assign hit[i] = (ld_addr == S_ADDR) && (ld_data == S_DATA);
  end

  assign key_hit = (ld_addr == ADDR_P) && (ld_data == CODE_ARM);

  always_comb begin
    kind = LD_DATA;
    if (live) begin
      if (idx == STEP_W'(KEY_LEN - 1) && key_hit) kind = LD_KEY_DONE;
      else if (hit[idx]) kind = (idx == STEP_W'(STEPS - 1)) ? LD_DIS_DONE : LD_PREFIX;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por || win_end) begin
      idx  <= '0;
      live <= 1'b1;
    end else if (ld_stb) begin
      if (kind == LD_PREFIX) idx <= idx + STEP_W'(1);
      else live <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_window_tracker.sv
`timescale 1ns/1ps
module wp_window_tracker import wp_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     por,
  input  logic     ld_stb,
  input  ld_kind_e kind,
  input  logic     win_end,
  output logic     key_ok,
  output logic     dis_ok,
  output logic     consumed
);
  logic key_q, dis_q;
  logic key_now, dis_now;

  assign key_now = ld_stb && (kind == LD_KEY_DONE);
  assign dis_now = ld_stb && (kind == LD_DIS_DONE);
  assign key_ok  = key_q || key_now;
  assign dis_ok  = dis_q || dis_now;

  always_ff @(posedge clk) begin
    if (rst || por) begin
      key_q    <= 1'b0;
      dis_q    <= 1'b0;
      consumed <= 1'b0;
    end else begin
      consumed <= ld_stb && (kind != LD_DATA);
      if (win_end) begin
        key_q <= 1'b0;
        dis_q <= 1'b0;
      end else begin
        if (key_now) key_q <= 1'b1;
        if (dis_now) dis_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_protect_reg.sv
`timescale 1ns/1ps
module wp_protect_reg (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic win_end,
  input  logic key_ok,
  input  logic dis_ok,
  output logic prot_on,
  output logic commit_en
);
  // Mode bit models nonvolatile storage: only the power-on default clears it.
  always_ff @(posedge clk) begin
    if (por) begin
      prot_on   <= 1'b0;
      commit_en <= 1'b0;
    end else if (rst) begin
      commit_en <= 1'b0;
    end else begin
      commit_en <= win_end && (!prot_on || key_ok || dis_ok);
      if (win_end) begin
        if (key_ok)      prot_on <= 1'b1;
        else if (dis_ok) prot_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wp_cmd_detect.sv
`timescale 1ns/1ps
module wp_cmd_detect import wp_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_OPEN   = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_CONF   = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM    = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_ERASE  = 8'h80,
  parameter logic [DATA_W-1:0] CODE_DISARM = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_default,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_end,
  output logic              prot_on,
  output logic              commit_en,
  output logic              consumed
);
  ld_kind_e kind;
  logic     key_ok, dis_ok;

  wp_seq_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_P(ADDR_P), .ADDR_Q(ADDR_Q),
    .CODE_OPEN(CODE_OPEN), .CODE_CONF(CODE_CONF), .CODE_ARM(CODE_ARM),
    .CODE_ERASE(CODE_ERASE), .CODE_DISARM(CODE_DISARM)
  ) u_match (
    .clk(clk), .rst(rst), .por(por_default), .ld_stb(ld_stb),
    .ld_addr(ld_addr), .ld_data(ld_data), .win_end(win_end), .kind(kind)
  );

  wp_window_tracker u_win (
    .clk(clk), .rst(rst), .por(por_default), .ld_stb(ld_stb), .kind(kind),
    .win_end(win_end), .key_ok(key_ok), .dis_ok(dis_ok), .consumed(consumed)
  );

  wp_protect_reg u_prot (
    .clk(clk), .rst(rst), .por(por_default), .win_end(win_end),
    .key_ok(key_ok), .dis_ok(dis_ok), .prot_on(prot_on), .commit_en(commit_en)
  );
endmodule

// File: rtl/wp_cmd_detect_chk.sv
`timescale 1ns/1ps
module wp_cmd_detect_chk (
  input logic clk,
  input logic rst,
  input logic por_default,
  input logic ld_stb,
  input logic win_end,
  input logic prot_on,
  input logic commit_en,
  input logic consumed
);
  assert_por_clears_R1: assert property (@(posedge clk) disable iff (rst)
    por_default |=> (!prot_on && !commit_en && !consumed));

  assert_mode_moves_only_at_end_R2: assert property (@(posedge clk) disable iff (por_default)
    !$stable(prot_on) |-> ($past(win_end) || $past(por_default)));

  assert_arm_commits_R3: assert property (@(posedge clk) disable iff (rst || por_default)
    $rose(prot_on) |-> commit_en);

  assert_consumed_after_load_R4: assert property (@(posedge clk) disable iff (rst || por_default)
    consumed |-> $past(ld_stb));

  assert_open_mode_commits_R8: assert property (@(posedge clk) disable iff (rst || por_default)
    (!$past(prot_on) && $past(win_end) && !$past(rst) && !$past(por_default)) |-> commit_en);

  assert_commit_after_end_R10: assert property (@(posedge clk) disable iff (rst || por_default)
    commit_en |-> $past(win_end));
endmodule

bind wp_cmd_detect wp_cmd_detect_chk u_chk (
  .clk(clk), .rst(rst), .por_default(por_default), .ld_stb(ld_stb),
  .win_end(win_end), .prot_on(prot_on), .commit_en(commit_en), .consumed(consumed)
);

// File: tb/tb_wp_cmd_detect.sv
`timescale 1ns/1ps
module tb_wp_cmd_detect;
  localparam logic [14:0] AP = 15'h5555;
  localparam logic [14:0] AQ = 15'h2AAA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_default = 1'b1;
  logic        ld_stb = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        win_end = 1'b0;
  logic        prot_on, commit_en, consumed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model state
  bit          m_prot = 1'b0;
  int          m_nld  = 0;
  logic [14:0] h_a [6];
  logic [7:0]  h_d [6];

  always #2.5 clk = ~clk;

  wp_cmd_detect dut (
    .clk(clk), .rst(rst), .por_default(por_default), .ld_stb(ld_stb),
    .ld_addr(ld_addr), .ld_data(ld_data), .win_end(win_end),
    .prot_on(prot_on), .commit_en(commit_en), .consumed(consumed)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit step_ok(bit dis, int i, logic [14:0] a, logic [7:0] d);
    logic [14:0] ea;
    logic [7:0]  ed;
    if (!dis && i > 2) return 1'b0;
    if (i > 5) return 1'b0;
    ea = (i == 1 || i == 4) ? AQ : AP;
    case (i)
      0, 3:    ed = 8'hAA;
      1, 4:    ed = 8'h55;
      2:       ed = dis ? 8'h80 : 8'hA0;
      default: ed = 8'h20;
    endcase
    return (a == ea) && (d == ed);
  endfunction

  function automatic bit prefix_ok(bit dis, int upto);
    for (int j = 0; j <= upto; j++)
      if (!step_ok(dis, j, h_a[j], h_d[j])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_load(logic [14:0] a, logic [7:0] d, string tag);
    bit exp_c;
    int k;
    k = m_nld;
    if (k < 6) begin h_a[k] = a; h_d[k] = d; end
    exp_c = (k < 6) && (prefix_ok(1'b0, k) || prefix_ok(1'b1, k));
    m_nld++;
    @(negedge clk);
    ld_stb = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    chk({tag, " consumed R4"}, int'(consumed), int'(exp_c));
    chk("commit idle during load R10", int'(commit_en), 0);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic do_end(string tag);
    bit kw, dw, ec;
    kw = (m_nld >= 3) && prefix_ok(1'b0, 2);
    dw = (m_nld >= 6) && prefix_ok(1'b1, 5);
    ec = !m_prot || kw || dw;
    if (kw) m_prot = 1'b1;
    else if (dw) m_prot = 1'b0;
    m_nld = 0;
    @(negedge clk);
    win_end = 1'b1;
    @(posedge clk); #1;
    chk({tag, " commit"}, int'(commit_en), int'(ec));
    chk({tag, " prot"}, int'(prot_on), int'(m_prot));
    @(negedge clk);
    win_end = 1'b0;
    @(posedge clk); #1;
    chk("commit one-cycle pulse R10", int'(commit_en), 0);
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_nld = 0;
  endtask

  task automatic send_key();
    do_load(AP, 8'hAA, "key1 R3");
    do_load(AQ, 8'h55, "key2 R3");
    do_load(AP, 8'hA0, "key3 R3");
  endtask

  task automatic send_disarm();
    do_load(AP, 8'hAA, "dis1 R9");
    do_load(AQ, 8'h55, "dis2 R9");
    do_load(AP, 8'h80, "dis3 R9");
    do_load(AP, 8'hAA, "dis4 R9");
    do_load(AQ, 8'h55, "dis5 R9");
    do_load(AP, 8'h20, "dis6 R9");
  endtask

  function automatic logic [7:0] pick_data();
    case ($urandom % 7)
      0: return 8'hAA;
      1: return 8'h55;
      2: return 8'hA0;
      3: return 8'h80;
      4: return 8'h20;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [14:0] pick_addr();
    case ($urandom % 4)
      0, 1: return AP;
      2:    return AQ;
      default: return 15'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk("reset prot R1", int'(prot_on), 0);
    chk("reset commit R1", int'(commit_en), 0);
    chk("reset consumed R1", int'(consumed), 0);
    @(negedge clk); por_default = 1'b0; rst = 1'b0;

    // Open mode: plain page commits
    do_load(15'h0100, 8'h3C, "plain");
    do_end("open mode R8");

    // Arm with key, followed by page data
    send_key();
    do_load(15'h0040, 8'h11, "after key data R4");
    do_end("arm R3 R7");

    // Protected, no key: dropped
    do_load(15'h0041, 8'h22, "unkeyed");
    do_end("unkeyed drop R6");

    // Ordinary reset keeps mode
    pulse_rst();
    @(posedge clk); #1;
    chk("rst keeps prot R2", int'(prot_on), 1);

    // Partial key before reset is forgotten
    do_load(AP, 8'hAA, "prefix before rst R2");
    pulse_rst();
    do_load(AQ, 8'h55, "after rst no prefix R2");
    do_end("after rst drop R2");

    // Keyed program while protected
    send_key();
    do_load(15'h0042, 8'h33, "keyed data");
    do_end("keyed commit R7");

    // Broken key at step three
    do_load(AP, 8'hAA, "brk1");
    do_load(AQ, 8'h55, "brk2");
    do_load(AP, 8'h11, "brk3 R5");
    do_load(AP, 8'hA0, "brk4 R5");
    do_end("broken key R5 R6");

    // Key after a data load
    do_load(15'h0007, 8'h77, "lead data R11");
    send_key();
    do_end("late key R11");

    // Disarm
    send_disarm();
    do_end("disarm R9");

    // Re-arm, then power-on default
    send_key();
    do_end("rearm R3");
    @(negedge clk); por_default = 1'b1;
    @(negedge clk); por_default = 1'b0;
    m_prot = 1'b0; m_nld = 0;
    #1;
    chk("por clears prot R1", int'(prot_on), 0);

    // Constrained random windows
    for (int w = 0; w < 300; w++) begin
      int len;
      len = 1 + ($urandom % 8);
      if (($urandom % 4) == 0) send_key();
      else if (($urandom % 8) == 0) send_disarm();
      for (int i = 0; i < len; i++) do_load(pick_addr(), pick_data(), "rand");
      do_end("rand window R6 R7 R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule